// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Lamp Test and Zero Blanking

This block turns a four-bit decimal digit code into the seven segment drive lines of a common-anode display. A segment lights when its line is driven low. The output is registered, so the drive lines change one clock after the inputs are sampled.

A lamp-test input lights every segment, so a display can be checked for dead segments. A blanking input and a blanking output let several decoders be chained, most significant digit first, to suppress leading zeros. A digit that receives a blanking request and holds the code zero goes dark. It then passes the request on to the next, less significant digit. The first nonzero digit ends the chain.

Codes 10 to 15 are not decimal. A parameter picks what they show: a single middle bar (a dash), or a dark digit.

Top module: `sevseg_rbdec`

## Requirements
- R1: Outputs are active low. `seg_n_o` is ordered {g,f,e,d,c,b,a}, so bit 0 is segment a and bit 6 is segment g. A 0 on a bit lights that segment.
- R2: When lamp test is inactive and blanking is not active, codes 0 to 9 light these segments, given here as active-high hex in {g..a} order: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. Digits 6 and 9 are drawn with their tails.
- R3: When `lamp_test_n_i` is low, `seg_n_o` is 7'h00 (all segments lit), whatever the code and the blanking input.
- R4: When lamp test is inactive, `blank_in_n_i` is low and the code is 0000, `seg_n_o` is 7'h7F (all segments dark) and `blank_out_n_o` is low.
- R5: In every other case `blank_out_n_o` is high. This covers `blank_in_n_i` high, a nonzero code (codes 10 to 15 included), and lamp test active.
- R6: Lamp test has priority over blanking. With `lamp_test_n_i` low, `blank_in_n_i` low and code 0000, all segments are lit and `blank_out_n_o` is high.
- R7: Codes 10 to 15 show only segment g (`seg_n_o` = 7'h3F) when `BLANK_INVALID` is 0. They show all segments dark (7'h7F) when `BLANK_INVALID` is 1. Blanking does not apply to these codes.
- R8: Outputs update on the rising clock edge after the inputs are applied. A synchronous active-high reset `rst` sets `seg_n_o` to 7'h7F and `blank_out_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_i | input | 4 | Digit code |
| lamp_test_n_i | input | 1 | Lamp test request, active low |
| blank_in_n_i | input | 1 | Zero-blanking request from the more significant digit, active low |
| seg_n_o | output | 7 | Segment drive {g,f,e,d,c,b,a}, active low |
| blank_out_n_o | output | 1 | Zero-blanking request to the less significant digit, active low |

## Verification
The bench builds two instances side by side and drives them with the same stimulus. One uses `BLANK_INVALID` = 0 and the other uses `BLANK_INVALID` = 1. Both variants of the out-of-range handling are therefore compared on every vector.

Every code from 0 to 15 is applied with blanking both off and on. Lamp test is applied across all blanking combinations. This reaches the priority corner (lamp test together with a blanked zero) and confirms that nonzero codes 10 to 15 never start a blanking chain.

// File: rtl/sevseg_pkg.sv
package sevseg_pkg;
    localparam int SEG_N  = 7;
    localparam int CODE_W = 4;

    typedef logic [SEG_N-1:0]  seg_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    // Registered drive state of one digit
    typedef struct packed {
        seg_vec_t seg_n;
        logic     chain_n;
    } drive_t;

    localparam seg_vec_t SEG_DARK = '1;
    localparam seg_vec_t SEG_FULL = '0;
endpackage

// File: rtl/sevseg_glyph.sv
// Maps a digit code to an active-high segment pattern {g..a}
module sevseg_glyph
    import sevseg_pkg::*;
#(
    parameter bit BLANK_INVALID = 1'b0
) (
    input  code_t    code_i,
    output seg_vec_t lit_o
);
    localparam int       MAX_DEC   = 9;
    localparam seg_vec_t DASH_LIT  = seg_vec_t'(7'h40);
    localparam seg_vec_t NONE_LIT  = seg_vec_t'(7'h00);

    seg_vec_t bad_glyph;

    generate
        if (BLANK_INVALID) begin : g_dark
            assign bad_glyph = NONE_LIT;
        end else begin : g_dash
            assign bad_glyph = DASH_LIT;
        end
    endgenerate

    always_comb begin
        if (int'(code_i) > MAX_DEC) begin
            lit_o = bad_glyph;
        end else begin
            unique case (code_i)
                4'd0:    lit_o = 7'h3F;
                4'd1:    lit_o = 7'h06;
                4'd2:    lit_o = 7'h5B;
                4'd3:    lit_o = 7'h4F;
                4'd4:    lit_o = 7'h66;
                4'd5:    lit_o = 7'h6D;
                4'd6:    lit_o = 7'h7D;
                4'd7:    lit_o = 7'h07;
                4'd8:    lit_o = 7'h7F;
                default: lit_o = 7'h6F;
            endcase
        end
    end
endmodule

// File: rtl/sevseg_gate.sv
// Applies lamp test and zero blanking to a glyph, producing active-low drive
module sevseg_gate
    import sevseg_pkg::*;
(
    input  seg_vec_t lit_i,
    input  logic     code_zero_i,
    input  logic     lamp_n_i,
    input  logic     rbi_n_i,
    output drive_t   drive_o
);
    always_comb begin
        drive_o.seg_n   = ~lit_i;
        drive_o.chain_n = 1'b1;
        if (!lamp_n_i) begin
            drive_o.seg_n = SEG_FULL;
        end else if (!rbi_n_i && code_zero_i) begin
            drive_o.seg_n   = SEG_DARK;
            drive_o.chain_n = 1'b0;
        end
    end
endmodule

// File: rtl/sevseg_rbdec.sv
module sevseg_rbdec
    import sevseg_pkg::*;
#(
    parameter bit BLANK_INVALID = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] bcd_i,
    input  logic              lamp_test_n_i,
    input  logic              blank_in_n_i,
    output logic [SEG_N-1:0]  seg_n_o,
    output logic              blank_out_n_o
);
    localparam drive_t RESET_DRIVE = '{seg_n: SEG_DARK, chain_n: 1'b1};

    seg_vec_t lit;
    logic     code_zero;
    drive_t   state_d;
    drive_t   state_q;

    assign code_zero = (bcd_i == '0);

    sevseg_glyph #(.BLANK_INVALID(BLANK_INVALID)) u_glyph (
        .code_i (bcd_i),
        .lit_o  (lit)
    );

    sevseg_gate u_gate (
        .lit_i       (lit),
        .code_zero_i (code_zero),
        .lamp_n_i    (lamp_test_n_i),
        .rbi_n_i     (blank_in_n_i),
        .drive_o     (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_DRIVE;
        end else begin
            state_q <= state_d;
        end
    end

    assign seg_n_o       = state_q.seg_n;
    assign blank_out_n_o = state_q.chain_n;
endmodule

// File: rtl/sevseg_rbdec_chk.sv
module sevseg_rbdec_chk #(
    parameter bit BLANK_INVALID = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] bcd_i,
    input logic       lamp_test_n_i,
    input logic       blank_in_n_i,
    input logic [6:0] seg_n_o,
    input logic       blank_out_n_o
);
    localparam logic [6:0] BAD_SEG = BLANK_INVALID ? 7'h7F : 7'h3F;

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (seg_n_o == 7'h7F && blank_out_n_o));

    // R3
    lamp_all_lit_chk: assert property (@(posedge clk) disable iff (rst)
        !lamp_test_n_i |=> (seg_n_o == 7'h00));

    // R4
    zero_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n_i && !blank_in_n_i && bcd_i == 4'd0)
            |=> (seg_n_o == 7'h7F && !blank_out_n_o));

    // R5
    chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_in_n_i || bcd_i != 4'd0 || !lamp_test_n_i) |=> blank_out_n_o);

    // R6
    lamp_over_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (!lamp_test_n_i && !blank_in_n_i) |=> (blank_out_n_o && seg_n_o == 7'h00));

    // R7
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n_i && bcd_i > 4'd9) |=> (seg_n_o == BAD_SEG));

    // R2
    eight_full_chk: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n_i && bcd_i == 4'd8) |=> (seg_n_o == 7'h00));
endmodule

bind sevseg_rbdec sevseg_rbdec_chk #(.BLANK_INVALID(BLANK_INVALID)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bcd_i         (bcd_i),
    .lamp_test_n_i (lamp_test_n_i),
    .blank_in_n_i  (blank_in_n_i),
    .seg_n_o       (seg_n_o),
    .blank_out_n_o (blank_out_n_o)
);

// File: tb/tb_sevseg_rbdec.sv
`timescale 1ns/1ps
module tb_sevseg_rbdec;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bcd = 4'd0;
    logic       lamp_n = 1'b1;
    logic       rbi_n = 1'b1;
    logic [6:0] seg_a, seg_b;
    logic       rbo_a, rbo_b;

    int applied = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [6:0] seg_dash;
        logic [6:0] seg_dark;
        logic       rbo;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    sevseg_rbdec #(.BLANK_INVALID(1'b0)) dut (
        .clk(clk), .rst(rst), .bcd_i(bcd), .lamp_test_n_i(lamp_n),
        .blank_in_n_i(rbi_n), .seg_n_o(seg_a), .blank_out_n_o(rbo_a));

    sevseg_rbdec #(.BLANK_INVALID(1'b1)) dut_dark (
        .clk(clk), .rst(rst), .bcd_i(bcd), .lamp_test_n_i(lamp_n),
        .blank_in_n_i(rbi_n), .seg_n_o(seg_b), .blank_out_n_o(rbo_b));

    // Active-high {g..a} glyph from the requirement table (R2, R7)
    function automatic logic [6:0] glyph(input logic [3:0] c, input bit dark_bad);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;
            4'd2: return 7'h5B;  4'd3: return 7'h4F;
            4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;
            4'd8: return 7'h7F;  4'd9: return 7'h6F;
            default: return dark_bad ? 7'h00 : 7'h40;
        endcase
    endfunction

    task automatic apply(input logic [3:0] c, input logic lt, input logic rb, input string req);
        exp_t e;
        @(negedge clk);
        bcd = c; lamp_n = lt; rbi_n = rb;
        if (!lt) begin
            e.seg_dash = 7'h00; e.seg_dark = 7'h00; e.rbo = 1'b1;
        end else if (!rb && c == 4'd0) begin
            e.seg_dash = 7'h7F; e.seg_dark = 7'h7F; e.rbo = 1'b0;
        end else begin
            e.seg_dash = ~glyph(c, 0); e.seg_dark = ~glyph(c, 1); e.rbo = 1'b1;
        end
        e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: results appear after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                applied++;
                if (seg_a !== e.seg_dash || seg_b !== e.seg_dark ||
                    rbo_a !== e.rbo || rbo_b !== e.rbo) begin
                    fails++;
                    $display("FAIL %s: bcd=%0d lt_n=%b rbi_n=%b seg=%h/%h rbo=%b/%b expected seg=%h/%h rbo=%b",
                             e.req, bcd, lamp_n, rbi_n, seg_a, seg_b, rbo_a, rbo_b,
                             e.seg_dash, e.seg_dark, e.rbo);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        applied++;
        if (seg_a !== 7'h7F || seg_b !== 7'h7F || rbo_a !== 1'b1 || rbo_b !== 1'b1) begin
            fails++;
            $display("FAIL R8: reset seg=%h/%h rbo=%b/%b expected seg=7f rbo=1",
                     seg_a, seg_b, rbo_a, rbo_b);
        end
        rst = 1'b0;

        // R1 R2 R7: every code, blanking off
        for (int c = 0; c < 16; c++) apply(4'(c), 1'b1, 1'b1, c < 10 ? "R2" : "R7");
        // R4 R5 R7: every code with blanking requested
        for (int c = 0; c < 16; c++) apply(4'(c), 1'b1, 1'b0, c == 0 ? "R4" : "R5");
        // R3: lamp test across codes, blanking off
        for (int c = 0; c < 16; c += 3) apply(4'(c), 1'b0, 1'b1, "R3");
        // R6: lamp test beats a blanked zero
        apply(4'd0, 1'b0, 1'b0, "R6");
        apply(4'd0, 1'b1, 1'b0, "R4");
        apply(4'd0, 1'b0, 1'b0, "R6");
        apply(4'd0, 1'b1, 1'b1, "R5");
        apply(4'd12, 1'b0, 1'b0, "R3");
        apply(4'd8, 1'b1, 1'b1, "R1");

        // R8: reset mid-stream returns to the dark state
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        applied++;
        if (seg_a !== 7'h7F || rbo_a !== 1'b1 || seg_b !== 7'h7F || rbo_b !== 1'b1) begin
            fails++;
            $display("FAIL R8: re-reset seg=%h/%h rbo=%b/%b expected seg=7f rbo=1",
                     seg_a, seg_b, rbo_a, rbo_b);
        end
        rst = 1'b0;
        apply(4'd3, 1'b1, 1'b1, "R8");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule